// File: doc/BRIEF.md
# Illegal Condition Reset Detector

This block sits beside a small processor core and watches three things: the instruction words the core fetches for execution, the working registers it writes and uses as address pointers, and every reload of the program counter. The reload may come from a call, jump, computed jump, return or other branch, or from an interrupt or trap vector. When the core fetches an illegal opcode, uses a working register that nothing has written since reset as an address pointer, or sends any counter reload to a restricted address inside a protected segment, the block raises a one-cycle reset request together with a 2-bit cause code.

The block does not decode instructions. The core tells it which registers were written and which register serves as a pointer. It also gives the target of each counter reload. Two protected segments are configured. Index 0 is the boot segment and index 1 is the secure segment. Each segment has an inclusive start and end address and a small set of allowed entry addresses. Every other address inside the segment is restricted.

All inputs are observation strobes. The block never stalls the core, so it has no ready signal and applies no back-pressure. A qualifier (`fetch_valid`, `ptr_valid`, `flow_valid`) marks each cycle in which the matching data bus is meaningful. After a request the block stays quiet until its own reset, which the device reset is expected to drive.

Top module: `illegal_reset_detector`

## Requirements
- R1: When `fetch_valid` is high and bits 23:16 of `fetch_word` equal 8'h3F, `rst_req` is high in the next cycle with `rst_cause` = 2'b01. Any other value of those bits gives no request.
- R2: An illegal word presented while `fetch_valid` is low raises no request.
- R3: After reset, working registers 0 to 14 are uninitialized. When `ptr_valid` is high and `ptr_sel` names one of them, `rst_req` is high in the next cycle with `rst_cause` = 2'b10.
- R4: Register 15 never triggers the uninitialized check.
- R5: Bit n of `reg_wr` marks register n as initialized from the next cycle on, and a later pointer use of it raises no request. A write in the same cycle as the pointer use does not prevent the request.
- R6: When `flow_valid` is high and `flow_target` lies within the inclusive start/end range of either segment without equalling one of that segment's entry addresses, `rst_req` is high in the next cycle with `rst_cause` = 2'b11.
- R7: A reload target equal to a configured entry address, or outside both segments, raises no request.
- R8: When several conditions occur in one cycle, the cause is chosen with illegal opcode first, then uninitialized register, then security.
- R9: `rst_req` is a pulse exactly one cycle long. `rst_cause` is 2'b00 before the first request and holds its value from the request until reset.
- R10: After a request, further conditions raise no request and leave `rst_cause` unchanged until reset.
- R11: Reset returns registers 0 to 14 to the uninitialized state, including registers written before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Instruction word is being fetched for execution |
| fetch_word | input | 24 | Fetched instruction word |
| reg_wr | input | 16 | Per-register write strobes |
| ptr_valid | input | 1 | A register is used as an address pointer this cycle |
| ptr_sel | input | 4 | Index of the pointer register |
| flow_valid | input | 1 | Program counter reload (branch or vector) this cycle |
| flow_target | input | 16 | Reload target address |
| seg_lo | input | 32 | Segment start addresses, 16 bits each, segment 0 in the low half |
| seg_hi | input | 32 | Segment end addresses, inclusive, same packing |
| seg_entry | input | 64 | Entry addresses, the entry e of segment s at slice (s*2+e)*16 |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | 01 opcode, 10 uninitialized register, 11 security |

## Verification
Several properties are checked on every cycle. The request never lasts beyond one cycle and always carries a non-zero cause. The cause stays zero until the first request and does not change after it. An illegal fetch is always followed by a request with the opcode cause. The bench scenarios cover what these properties cannot show. They sweep every upper opcode byte, every pointer register with and without a prior write, and every reload target across both segments with their entry addresses. They also cover simultaneous conditions, the silence after a request, and the clearing of the register bitmap by reset.

// File: rtl/irst_pkg.sv
package irst_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_OPCODE = 2'b01,
    CAUSE_UNINIT = 2'b10,
    CAUSE_SECURE = 2'b11
  } cause_e;
endpackage

// File: rtl/irst_opcode_chk.sv
module irst_opcode_chk #(
  parameter int WORD_W  = 24,
  parameter int OPC_W   = 8,
  parameter logic [OPC_W-1:0] ILLEGAL = 8'h3F
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              bad
);
  assign bad = valid && (word[WORD_W-1 -: OPC_W] == ILLEGAL);
endmodule

// File: rtl/irst_reg_track.sv
module irst_reg_track #(
  parameter int NREG   = 16,
  parameter int EXEMPT = 15,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  wr,
  input  logic             use_valid,
  input  logic [SEL_W-1:0] use_sel,
  output logic             uninit
);
  localparam logic [NREG-1:0] RST_MAP = NREG'(1) << EXEMPT;

  logic [NREG-1:0] init_map;

  always_ff @(posedge clk) begin
    if (!rst_n) init_map <= RST_MAP;
    else        init_map <= init_map | wr | RST_MAP;
  end

  // Pointer use is judged against the map as it stood before this cycle's writes
  assign uninit = use_valid && !init_map[use_sel];
endmodule

// File: rtl/irst_seg_chk.sv
module irst_seg_chk #(
  parameter int ADDR_W    = 16,
  parameter int NUM_ENTRY = 2
) (
  input  logic                          valid,
  input  logic [ADDR_W-1:0]             target,
  input  logic [ADDR_W-1:0]             lo,
  input  logic [ADDR_W-1:0]             hi,
  input  logic [NUM_ENTRY*ADDR_W-1:0]   entries,
  output logic                          restricted
);
  logic in_range;
  logic entry_hit;

  always_comb begin
    entry_hit = 1'b0;
    for (int e = 0; e < NUM_ENTRY; e++) begin
      if (entries[e*ADDR_W +: ADDR_W] == target) entry_hit = 1'b1;
    end
  end

  assign in_range   = (target >= lo) && (target <= hi);
  assign restricted = valid && in_range && !entry_hit;
endmodule

// File: rtl/illegal_reset_detector.sv
module illegal_reset_detector #(
  parameter int WORD_W    = 24,
  parameter int NREG      = 16,
  parameter int ADDR_W    = 16,
  parameter int NUM_SEG   = 2,
  parameter int NUM_ENTRY = 2,
  localparam int SEL_W    = $clog2(NREG)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fetch_valid,
  input  logic [WORD_W-1:0]                    fetch_word,
  input  logic [NREG-1:0]                      reg_wr,
  input  logic                                 ptr_valid,
  input  logic [SEL_W-1:0]                     ptr_sel,
  input  logic                                 flow_valid,
  input  logic [ADDR_W-1:0]                    flow_target,
  input  logic [NUM_SEG*ADDR_W-1:0]            seg_lo,
  input  logic [NUM_SEG*ADDR_W-1:0]            seg_hi,
  input  logic [NUM_SEG*NUM_ENTRY*ADDR_W-1:0]  seg_entry,
  output logic                                 rst_req,
  output logic [1:0]                           rst_cause
);
  import irst_pkg::*;

  logic               op_bad;
  logic               reg_bad;
  logic [NUM_SEG-1:0] seg_bad;
  logic               sec_bad;
  logic               done;
  logic               req_d;
  cause_e             cause_d;

  irst_opcode_chk #(.WORD_W(WORD_W)) u_opc (
    .valid (fetch_valid),
    .word  (fetch_word),
    .bad   (op_bad)
  );

  irst_reg_track #(.NREG(NREG), .EXEMPT(NREG-1)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .use_valid (ptr_valid),
    .use_sel   (ptr_sel),
    .uninit    (reg_bad)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    irst_seg_chk #(.ADDR_W(ADDR_W), .NUM_ENTRY(NUM_ENTRY)) u_seg (
      .valid      (flow_valid),
      .target     (flow_target),
      .lo         (seg_lo[s*ADDR_W +: ADDR_W]),
      .hi         (seg_hi[s*ADDR_W +: ADDR_W]),
      .entries    (seg_entry[s*NUM_ENTRY*ADDR_W +: NUM_ENTRY*ADDR_W]),
      .restricted (seg_bad[s])
    );
  end

  assign sec_bad = |seg_bad;
  assign req_d   = !done && (op_bad || reg_bad || sec_bad);

  always_comb begin
    if (op_bad)       cause_d = CAUSE_OPCODE;
    else if (reg_bad) cause_d = CAUSE_UNINIT;
    else              cause_d = CAUSE_SECURE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      rst_cause <= CAUSE_NONE;
      done      <= 1'b0;
    end else begin
      rst_req <= req_d;
      if (req_d) begin
        rst_cause <= cause_d;
        done      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/illegal_reset_detector_chk.sv
module illegal_reset_detector_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [WORD_W-1:0] fetch_word,
  input logic              rst_req,
  input logic [1:0]        rst_cause
);
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen <= 1'b0;
    else if (rst_req) seen <= 1'b1;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);  // R9
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rst_cause != 2'b00);  // R9
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !rst_req) |-> rst_cause == 2'b00);  // R9
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> $stable(rst_cause));  // R10
  AST_OPCODE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !rst_req && fetch_valid && fetch_word[WORD_W-1 -: 8] == 8'h3F)
      |=> (rst_req && rst_cause == 2'b01));  // R1
endmodule

bind illegal_reset_detector illegal_reset_detector_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_word  (fetch_word),
  .rst_req     (rst_req),
  .rst_cause   (rst_cause)
);

// File: tb/illegal_reset_detector_tb.sv
module illegal_reset_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [23:0] fetch_word = '0;
  logic [15:0] reg_wr = '0;
  logic        ptr_valid = 1'b0;
  logic [3:0]  ptr_sel = '0;
  logic        flow_valid = 1'b0;
  logic [15:0] flow_target = '0;
  logic [31:0] seg_lo    = {16'h0400, 16'h0100};
  logic [31:0] seg_hi    = {16'h04FF, 16'h01FF};
  logic [63:0] seg_entry = {16'h0440, 16'h0400, 16'h0180, 16'h0100};
  logic        rst_req;
  logic [1:0]  rst_cause;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  illegal_reset_detector u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .reg_wr(reg_wr), .ptr_valid(ptr_valid), .ptr_sel(ptr_sel),
    .flow_valid(flow_valid), .flow_target(flow_target),
    .seg_lo(seg_lo), .seg_hi(seg_hi), .seg_entry(seg_entry),
    .rst_req(rst_req), .rst_cause(rst_cause)
  );

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive for one cycle, clear, then return at the negedge after the capturing edge
  task automatic idle_cycle();
    @(negedge clk);
    fetch_valid = 0; ptr_valid = 0; flow_valid = 0; reg_wr = '0;
  endtask

  function automatic logic [2:0] pack(logic r, logic [1:0] c);
    return {r, c};
  endfunction

  function automatic logic restricted(logic [15:0] t);
    if (t >= 16'h0100 && t <= 16'h01FF && t != 16'h0100 && t != 16'h0180) return 1'b1;
    if (t >= 16'h0400 && t <= 16'h04FF && t != 16'h0400 && t != 16'h0440) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("reset R9", pack(rst_req, rst_cause), 3'b000);

    // R1: every upper byte value
    for (int b = 0; b < 256; b++) begin
      do_reset();
      fetch_valid = 1; fetch_word = {b[7:0], 16'hA5C3};
      idle_cycle();
      chk("R1 opcode sweep", pack(rst_req, rst_cause), (b == 8'h3F) ? 3'b101 : 3'b000);
    end

    // R2: qualifier low
    do_reset();
    fetch_valid = 0; fetch_word = 24'h3F0000;
    idle_cycle();
    chk("R2 unqualified fetch", pack(rst_req, rst_cause), 3'b000);

    // R3/R4: pointer use straight after reset
    for (int r = 0; r < 16; r++) begin
      do_reset();
      ptr_valid = 1; ptr_sel = r[3:0];
      idle_cycle();
      chk(r == 15 ? "R4 exempt register" : "R3 uninit pointer",
          pack(rst_req, rst_cause), (r == 15) ? 3'b000 : 3'b110);
    end

    // R5: written registers, then uninitialized neighbour
    for (int r = 0; r < 15; r++) begin
      do_reset();
      reg_wr = 16'(1) << r;
      idle_cycle();
      ptr_valid = 1; ptr_sel = r[3:0];
      idle_cycle();
      chk("R5 written register", pack(rst_req, rst_cause), 3'b000);
      ptr_valid = 1; ptr_sel = 4'((r + 1) % 15);
      idle_cycle();
      chk("R5 other register", pack(rst_req, rst_cause), 3'b110);
    end
    do_reset();
    reg_wr = 16'h0008; ptr_valid = 1; ptr_sel = 4'd3;
    idle_cycle();
    chk("R5 same-cycle write", pack(rst_req, rst_cause), 3'b110);

    // R6/R7: every target across and around both segments
    for (int t = 0; t < 16'h0600; t++) begin
      do_reset();
      flow_valid = 1; flow_target = t[15:0];
      idle_cycle();
      chk(restricted(t[15:0]) ? "R6 restricted target" : "R7 allowed target",
          pack(rst_req, rst_cause), restricted(t[15:0]) ? 3'b111 : 3'b000);
    end

    // R8: priority
    do_reset();
    fetch_valid = 1; fetch_word = 24'h3F1234; ptr_valid = 1; ptr_sel = 4'd2;
    flow_valid = 1; flow_target = 16'h0101;
    idle_cycle();
    chk("R8 opcode first", pack(rst_req, rst_cause), 3'b101);
    do_reset();
    ptr_valid = 1; ptr_sel = 4'd2; flow_valid = 1; flow_target = 16'h0401;
    idle_cycle();
    chk("R8 uninit before security", pack(rst_req, rst_cause), 3'b110);

    // R9/R10: pulse, hold, silence
    do_reset();
    flow_valid = 1; flow_target = 16'h0150;
    idle_cycle();
    chk("R9 request", pack(rst_req, rst_cause), 3'b111);
    fetch_valid = 1; fetch_word = 24'h3F0000; ptr_valid = 1; ptr_sel = 4'd0;
    idle_cycle();
    chk("R9 pulse ends", pack(rst_req, rst_cause), 3'b011);
    idle_cycle();
    chk("R10 silent after request", pack(rst_req, rst_cause), 3'b011);

    // R11: reset clears written map
    do_reset();
    reg_wr = 16'h7FFF;
    idle_cycle();
    ptr_valid = 1; ptr_sel = 4'd9;
    idle_cycle();
    chk("R11 before reset", pack(rst_req, rst_cause), 3'b000);
    do_reset();
    ptr_valid = 1; ptr_sel = 4'd9;
    idle_cycle();
    chk("R11 after reset", pack(rst_req, rst_cause), 3'b110);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule